// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This block sits between the read port of a word-wide data memory and the register writeback path. Each cycle it may accept one load. It receives the byte offset of the load address within the aligned word, the access size, the kind of load, a sign-extension select, the word read from memory and the current value of the destination register. One clock later it returns the value to write back, or it raises a misalignment trap instead.

A normal load of a byte, halfword or word picks the addressed bytes out of the memory word, right-justifies them and extends them. A normal halfword or word load at an address that does not fit its size is not serviced: the trap output rises and the old register value passes through unchanged, so that a software handler can emulate the access. An unaligned word can still be read without a trap by issuing two partial loads. A left-partial load fills the upper end of the register, and a right-partial load fills the lower end. Each of them keeps the bytes of the old register value that it does not replace.

Byte order is big-endian. Byte offset 0 of a memory word is its most significant byte, `memWord[31:24]` at the default width.

Top module: `load_merge_unit`

## Requirements
- R1: The result appears one clock after the load is accepted: `outValid` is the value `inValid` had at the previous rising edge. While `rstN` is low, `outValid`, `outTrap` and `outData` are cleared to zero.
- R2: The byte at offset k of `memWord` is bits [31-8k:24-8k]. A normal word load (`loadKind`=00, `accSize`=10) at offset 0 returns `memWord` unchanged.
- R3: A normal load traps when it is misaligned. A word traps when `byteOff` is not 00. A halfword (`accSize`=01) traps when `byteOff[0]` is 1. A byte (`accSize`=00) never traps.
- R4: A normal byte load returns the addressed byte in bits [7:0]. The upper bits are copies of bit 7 of that byte when `signExt`=1, and zero when `signExt`=0.
- R5: An aligned normal halfword load returns the bytes at offsets o and o+1 in bits [15:0], with the byte at offset o in bits [15:8]. The upper 16 bits are sign- or zero-extended according to `signExt`.
- R6: When the trap is raised, `outTrap`=1 and `outData` equals the old register value.
- R7: A left-partial load (`loadKind`=01) at offset o places the memory bytes at offsets o through 3 in the top 4-o byte lanes of the result, in order. The low o lanes keep the old register bytes.
- R8: A right-partial load (`loadKind`=10) at offset o places the memory bytes at offsets 0 through o in the low o+1 byte lanes of the result, with offset o in bits [7:0]. The remaining high lanes keep the old register bytes.
- R9: Partial loads never raise the trap, and their result does not depend on `accSize` or `signExt`.
- R10: A left-partial load at address A, followed by a right-partial load at address A+3 whose old value is the first result, yields the big-endian word made of the bytes at A, A+1, A+2 and A+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A load is presented this cycle |
| byteOff | input | 2 | Low address bits: byte offset within the word |
| accSize | input | 2 | 00 byte, 01 halfword, 10 word |
| loadKind | input | 2 | 00 normal, 01 left-partial, 10 right-partial |
| signExt | input | 1 | 1 sign-extends, 0 zero-extends normal byte/halfword loads |
| memWord | input | 32 | Aligned word read from memory |
| oldReg | input | 32 | Current destination register value |
| outValid | output | 1 | Result valid |
| outData | output | 32 | Value to write back |
| outTrap | output | 1 | Misaligned normal load; the handler must emulate it |

## Verification
The bench builds the block with its default of four byte lanes. At that width every byte offset can be reached for every size and load kind, so the misaligned halfword and word cases and each partial-load split point are covered exhaustively. The extension checks use memory bytes whose top bit is 1 and bytes whose top bit is 0. The paired partial loads are compared with the unaligned word assembled byte by byte from a two-word memory image, for each of the three misaligned offsets.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [1:0] KIND_NORMAL = 2'b00;
  localparam logic [1:0] KIND_LEFT   = 2'b01;
  localparam logic [1:0] KIND_RIGHT  = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic [7:0] shamt;       // byte shift amount
    logic       shiftLeft;   // 1: shift toward MSB
    logic       keepLo;      // 1: keep lanes below keepN, 0: keep lanes at/above keepN
    logic [3:0] keepN;
    logic       extOn;       // fill lanes at/above fieldBytes with extension
    logic [3:0] fieldBytes;
    logic       signExt;
    logic       trap;
  } laneCtl_t;
endpackage

// File: rtl/lmu_ctrl.sv
module lmu_ctrl
  import lmu_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] byteOff,
  input  logic [1:0]       accSize,
  input  logic [1:0]       loadKind,
  input  logic             signExt,
  output laneCtl_t         ctl
);
  int  fieldLen;
  logic misaligned;

  always_comb begin
    ctl        = '0;
    ctl.fieldBytes = 4'd1;
    fieldLen   = 1;
    misaligned = 1'b0;
    case (loadKind)
      KIND_LEFT: begin
        ctl.shiftLeft = 1'b1;
        ctl.shamt     = 8'(byteOff);
        ctl.keepLo    = 1'b1;
        ctl.keepN     = 4'(byteOff);
      end
      KIND_RIGHT: begin
        ctl.shamt  = 8'(BYTES - 1 - int'(byteOff));
        ctl.keepLo = 1'b0;
        ctl.keepN  = 4'(int'(byteOff) + 1);
      end
      default: begin
        case (accSize)
          SZ_BYTE: fieldLen = 1;
          SZ_HALF: begin
            fieldLen   = 2;
            misaligned = byteOff[0];
          end
          default: begin
            fieldLen   = BYTES;
            misaligned = (byteOff != '0);
          end
        endcase
        ctl.fieldBytes = 4'(fieldLen);
        ctl.extOn      = 1'b1;
        ctl.signExt    = signExt;
        ctl.keepLo     = 1'b1;
        if (misaligned) begin
          ctl.trap  = 1'b1;
          ctl.keepN = 4'(BYTES);
        end else begin
          ctl.shamt = 8'(BYTES - int'(byteOff) - fieldLen);
          ctl.keepN = 4'd0;
        end
      end
    endcase
  end
endmodule

// File: rtl/lmu_datapath.sv
module lmu_datapath
  import lmu_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DATA_W = 8 * BYTES,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] memWord,
  input  logic [DATA_W-1:0] oldReg,
  input  laneCtl_t          ctl,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outTrap
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] merged;
  logic [10:0]       bitShift;
  logic [IDX_W-1:0]  signIdx;
  logic [7:0]        fillByte;

  assign bitShift = {ctl.shamt, 3'b000};
  assign shifted  = ctl.shiftLeft ? (memWord << bitShift) : (memWord >> bitShift);
  assign signIdx  = IDX_W'(8 * int'(ctl.fieldBytes) - 1);
  assign fillByte = {8{ctl.signExt & shifted[signIdx]}};

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic keepOld, extLane;
    assign keepOld = ctl.keepLo ? (4'(j) < ctl.keepN) : (4'(j) >= ctl.keepN);
    assign extLane = ctl.extOn && (4'(j) >= ctl.fieldBytes);
    assign merged[8*j +: 8] = keepOld ? oldReg[8*j +: 8] :
                              extLane ? fillByte : shifted[8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outTrap  <= 1'b0;
    end else begin
      outValid <= inValid;
      outData  <= merged;
      outTrap  <= inValid & ctl.trap;
    end
  end

  // R6: a trapping result carries the register value untouched
  a_r6_trap_keeps_old: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.trap) |=> (outTrap && outData == $past(oldReg)));
endmodule

// File: rtl/load_merge_unit.sv
module load_merge_unit
  import lmu_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DATA_W = 8 * BYTES,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [1:0]        accSize,
  input  logic [1:0]        loadKind,
  input  logic              signExt,
  input  logic [DATA_W-1:0] memWord,
  input  logic [DATA_W-1:0] oldReg,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outTrap
);
  laneCtl_t ctl;

  lmu_ctrl #(.BYTES(BYTES)) u_ctrl (
    .byteOff(byteOff), .accSize(accSize), .loadKind(loadKind),
    .signExt(signExt), .ctl(ctl)
  );

  lmu_datapath #(.BYTES(BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .memWord(memWord),
    .oldReg(oldReg), .ctl(ctl), .outValid(outValid), .outData(outData),
    .outTrap(outTrap)
  );

  // R1: one-cycle valid pipeline
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9: partial loads never trap
  a_r9_partial_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (loadKind == KIND_LEFT || loadKind == KIND_RIGHT)) |=> !outTrap);

  // R3: misaligned normal word always traps
  a_r3_word_traps: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && loadKind == KIND_NORMAL && accSize == SZ_WORD && byteOff != '0)
      |=> outTrap);

  // R4: zero-extended byte has clear upper bits
  a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && loadKind == KIND_NORMAL && accSize == SZ_BYTE && !signExt)
      |=> (outData[DATA_W-1:8] == '0 && !outTrap));
endmodule

// File: tb/tb_load_merge_unit.sv
`timescale 1ns/1ps
module tb_load_merge_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  byteOff = '0;
  logic [1:0]  accSize = '0;
  logic [1:0]  loadKind = '0;
  logic        signExt = 1'b0;
  logic [31:0] memWord = '0;
  logic [31:0] oldReg = '0;
  logic        outValid;
  logic [31:0] outData;
  logic        outTrap;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        trap;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  load_merge_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .byteOff(byteOff),
    .accSize(accSize), .loadKind(loadKind), .signExt(signExt),
    .memWord(memWord), .oldReg(oldReg), .outValid(outValid),
    .outData(outData), .outTrap(outTrap)
  );

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // Independent reference built from the requirement text
  function automatic void model(input logic [1:0] o, input logic [1:0] sz,
                                input logic [1:0] kind, input logic sx,
                                input logic [31:0] mem, input logic [31:0] old,
                                output logic [31:0] d, output logic t);
    logic [7:0] m [4];
    int oi;
    oi = int'(o);
    for (int k = 0; k < 4; k++) m[k] = mem[31-8*k -: 8];
    d = old;
    t = 1'b0;
    if (kind == 2'b01) begin
      for (int k = 0; k < 4 - oi; k++) d[31-8*k -: 8] = m[oi+k];
    end else if (kind == 2'b10) begin
      for (int k = 0; k <= oi; k++) d[8*(oi-k) +: 8] = m[k];
    end else if (sz == 2'b00) begin
      d = {{24{sx & m[oi][7]}}, m[oi]};
    end else if (sz == 2'b01) begin
      if (o[0]) t = 1'b1;
      else d = {{16{sx & m[oi][7]}}, m[oi], m[oi+1]};
    end else begin
      if (o != 2'b00) t = 1'b1;
      else d = mem;
    end
  endfunction

  task automatic drive(input logic [1:0] o, input logic [1:0] sz,
                       input logic [1:0] kind, input logic sx,
                       input logic [31:0] mem, input logic [31:0] old,
                       input string tag);
    exp_t e;
    model(o, sz, kind, sx, mem, old, e.data, e.trap);
    e.tag = tag;
    @(negedge clk);
    inValid = 1'b1; byteOff = o; accSize = sz; loadKind = kind;
    signExt = sx; memWord = mem; oldReg = old;
    expQ.push_back(e);
  endtask

  task automatic driveExp(input logic [1:0] o, input logic [1:0] kind,
                          input logic [31:0] mem, input logic [31:0] old,
                          input logic [31:0] expData, input string tag);
    exp_t e;
    e.data = expData; e.trap = 1'b0; e.tag = tag;
    @(negedge clk);
    inValid = 1'b1; byteOff = o; accSize = 2'b10; loadKind = kind;
    signExt = 1'b1; memWord = mem; oldReg = old;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R1 unexpected result", {31'b0, outValid}, 32'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " data"}, outData, e.data);
        check({e.tag, " trap"}, {31'b0, outTrap}, {31'b0, e.trap});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] img [8];
    logic [31:0] w0, w1, leftRes, want;
    logic t;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outValid", {31'b0, outValid}, 32'h0);
    check("R1 reset outTrap", {31'b0, outTrap}, 32'h0);
    check("R1 reset outData", outData, 32'h0);
    rstN = 1'b1;

    // R2: aligned words, big-endian lane mapping
    drive(2'd0, 2'b10, 2'b00, 1'b0, 32'h0000_0203, 32'hFFFF_FFFF, "R2");
    drive(2'd0, 2'b10, 2'b00, 1'b1, 32'h8123_4567, 32'h0, "R2");
    drive(2'd0, 2'b10, 2'b00, 1'b0, 32'hA5A5_5A5A, 32'h1111_1111, "R2");

    // R4: bytes at every offset, sign and zero extension
    for (int o = 0; o < 4; o++) begin
      drive(2'(o), 2'b00, 2'b00, 1'b0, 32'h80_7F_FF_01, 32'hCAFE_F00D, "R4");
      drive(2'(o), 2'b00, 2'b00, 1'b1, 32'h80_7F_FF_01, 32'hCAFE_F00D, "R4");
    end

    // R5: aligned halves
    for (int o = 0; o < 4; o += 2) begin
      drive(2'(o), 2'b01, 2'b00, 1'b0, 32'h8001_7FFE, 32'h5555_5555, "R5");
      drive(2'(o), 2'b01, 2'b00, 1'b1, 32'h8001_7FFE, 32'h5555_5555, "R5");
    end
    drive(2'd2, 2'b01, 2'b00, 1'b1, 32'hFFFF_0203, 32'h0, "R5");

    // R3/R6: misaligned normal loads trap and pass the old value
    drive(2'd1, 2'b01, 2'b00, 1'b0, 32'h1234_5678, 32'h0BAD_CAFE, "R3 R6");
    drive(2'd3, 2'b01, 2'b00, 1'b1, 32'h1234_5678, 32'h0BAD_CAFE, "R3 R6");
    for (int o = 1; o < 4; o++)
      drive(2'(o), 2'b10, 2'b00, 1'b0, 32'h1234_5678, 32'hFEED_0000 + o, "R3 R6");

    // R7 / R8 at every offset, with varying size and sign select (R9)
    for (int o = 0; o < 4; o++) begin
      drive(2'(o), 2'(o % 3), 2'b01, 1'(o & 1), 32'h8899_AABB, 32'h1122_3344, "R7 R9");
      drive(2'(o), 2'((o + 1) % 3), 2'b10, 1'(~o & 1), 32'h8899_AABB, 32'h1122_3344, "R8 R9");
    end
    idle(3);
    // R1: idle input gives no result
    check("R1 idle outValid", {31'b0, outValid}, 32'h0);

    // R10: unaligned word assembled from two partial loads
    for (int k = 0; k < 8; k++) img[k] = 8'(8'h90 + 8'(k * 17));
    w0 = {img[0], img[1], img[2], img[3]};
    w1 = {img[4], img[5], img[6], img[7]};
    for (int a = 1; a < 4; a++) begin
      model(2'(a), 2'b10, 2'b01, 1'b0, w0, 32'hDEAD_BEEF, leftRes, t);
      want = {img[a], img[a+1], img[a+2], img[a+3]};
      driveExp(2'(a), 2'b01, w0, 32'hDEAD_BEEF, leftRes, "R10 left");
      driveExp(2'((a + 3) % 4), 2'b10, w1, leftRes, want, "R10 pair");
    end
    idle(4);
    check("R1 scoreboard drained", 32'(expQ.size()), 32'h0);
    finish_run();
  end
endmodule